// File: doc/BRIEF.md
# Trap Status and Cause Unit

This block sits beside a simple processor pipeline and decides, every cycle, whether control must be diverted to a trap handler. It also records why the diversion happened and at which instruction address. Eight external interrupt request lines and three synchronous fault strobes come in: illegal opcode, arithmetic overflow and divide by zero. The address of the current instruction comes in as well. A single take-trap output goes high in the same cycle as the triggering condition. A saved program counter is kept for the handler.

Software controls the unit through a small indexed register port. Writes are synchronous and reads are combinational. The Status register (index 12) holds a global interrupt enable and a per-line interrupt mask. The Cause register (index 13) is read-only. It holds a 4-bit reason code and shows the live state of every request line. Index 14 returns the saved program counter. Exceptions share the trap path with interrupts. An exception is taken whatever the enable state, and it wins over a simultaneous interrupt. Entering a trap clears the global enable, so the handler is not re-entered by the same request.

Top module: `trap_ctl_unit`

## Requirements
- R1: While Status bit 0 (global enable) is 0, no interrupt line raises `trap_o`.
- R2: Request line n (n = 0..7) raises `trap_o` only when it is high, Status bit 8+n is set and Status bit 0 is set.
- R3: A write to index 12 stores bit 0 and bits 15:8 of the write data. All other Status bits read as 0. For example, writing 0x1001 reads back as 0x1001 and enables line 4 only.
- R4: A read of index 13 returns the raw request lines in bits 15:8 every cycle, whatever the mask, and the reason code in bits 5:2. All other bits read 0. Writes to index 13 have no effect.
- R5: Any exception strobe raises `trap_o` in the same cycle, regardless of Status. From the next cycle the Cause code reads 0xA for illegal opcode, 0xC for overflow and 0xD for divide by zero. When several strobes are active together, the priority is illegal, then overflow, then divide by zero.
- R6: An exception and an enabled interrupt in the same cycle record the exception's code.
- R7: A trap taken for an interrupt records the code 0000.
- R8: In a trap cycle `pc_i` is captured. It appears on `epc_o` and at index 14 from the next cycle. Otherwise the saved value holds, and writes to index 14 have no effect.
- R9: A trap clears Status bit 0 in the next cycle. This overrides a software write in the same cycle, while the mask bits of that write are still stored.
- R10: After reset, Status, the Cause code and the saved PC are 0. A read of any index other than 12, 13 or 14 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 8 | External interrupt request lines |
| exc_illegal_i | input | 1 | Illegal opcode strobe |
| exc_ovf_i | input | 1 | Arithmetic overflow strobe |
| exc_divz_i | input | 1 | Divide-by-zero strobe |
| pc_i | input | 32 | Address of the instruction in flight |
| reg_idx_i | input | 5 | Register index for the access port |
| reg_wr_i | input | 1 | Write strobe for the access port |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_idx_i`, combinational |
| trap_o | output | 1 | Take-trap signal |
| epc_o | output | 32 | Saved program counter |

## Verification
A corrupt enable or mask bit shows up as a missing or spurious `trap_o` in the first cycle that a request line is driven. It also shows up immediately in an index 12 read. A wrong reason code or a wrong saved PC is visible one cycle after the trap, through index 13, index 14 and `epc_o`. A saved PC that fails to hold shows as a drift on `epc_o` during idle cycles. The stimulus therefore pairs each trap cycle with reads in the following cycle. It also drives conflicting events in one cycle: several strobes together, a strobe with an interrupt, and a trap with a Status write.

// File: rtl/trap_pkg.sv
package trap_pkg;
    parameter int unsigned XLEN      = 32;
    parameter int unsigned NUM_IRQ   = 8;
    parameter int unsigned IDX_W     = 5;
    parameter int unsigned CODE_W    = 4;
    parameter int unsigned CODE_LSB  = 2;
    parameter int unsigned MASK_LSB  = 8;
    parameter int unsigned IDX_STATUS = 12;
    parameter int unsigned IDX_CAUSE  = 13;
    parameter int unsigned IDX_EPC    = 14;

    typedef enum logic [CODE_W-1:0] {
        CODE_INT  = 4'h0,
        CODE_ILL  = 4'hA,
        CODE_OVF  = 4'hC,
        CODE_DIVZ = 4'hD
    } exc_code_e;

    typedef struct packed {
        logic                gie;
        logic [NUM_IRQ-1:0]  mask;
        exc_code_e           code;
        logic [XLEN-1:0]     epc;
    } trap_state_t;
endpackage

// File: rtl/trap_exc_encode.sv
module trap_exc_encode
    import trap_pkg::*;
(
    input  logic      ill_i,
    input  logic      ovf_i,
    input  logic      divz_i,
    output logic      valid_o,
    output exc_code_e code_o
);
    always_comb begin
        valid_o = ill_i | ovf_i | divz_i;
        if (ill_i) begin
            code_o = CODE_ILL;
        end else if (ovf_i) begin
            code_o = CODE_OVF;
        end else if (divz_i) begin
            code_o = CODE_DIVZ;
        end else begin
            code_o = CODE_INT;
        end
    end
endmodule

// File: rtl/trap_irq_gate.sv
module trap_irq_gate #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] mask_i,
    input  logic         gie_i,
    output logic         hit_o
);
    logic [N-1:0] live;

    for (genvar g = 0; g < N; g++) begin : g_line
        assign live[g] = req_i[g] & mask_i[g];
    end

    assign hit_o = gie_i & (|live);
endmodule

// File: rtl/trap_read_mux.sv
module trap_read_mux
    import trap_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned N  = 8,
    parameter int unsigned IW = 5
) (
    input  logic [IW-1:0] idx_i,
    input  logic          gie_i,
    input  logic [N-1:0]  mask_i,
    input  exc_code_e     code_i,
    input  logic [N-1:0]  irq_i,
    input  logic [W-1:0]  epc_i,
    output logic [W-1:0]  rdata_o
);
    localparam logic [IW-1:0] SEL_STATUS = IW'(IDX_STATUS);
    localparam logic [IW-1:0] SEL_CAUSE  = IW'(IDX_CAUSE);
    localparam logic [IW-1:0] SEL_EPC    = IW'(IDX_EPC);

    always_comb begin
        rdata_o = '0;
        unique case (idx_i)
            SEL_STATUS: begin
                rdata_o[0]               = gie_i;
                rdata_o[MASK_LSB +: N]   = mask_i;
            end
            SEL_CAUSE: begin
                rdata_o[CODE_LSB +: CODE_W] = code_i;
                rdata_o[MASK_LSB +: N]      = irq_i;
            end
            SEL_EPC: rdata_o = epc_i;
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/trap_ctl_unit.sv
module trap_ctl_unit
    import trap_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IRQ-1:0]  irq_i,
    input  logic                exc_illegal_i,
    input  logic                exc_ovf_i,
    input  logic                exc_divz_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic [IDX_W-1:0]    reg_idx_i,
    input  logic                reg_wr_i,
    input  logic [XLEN-1:0]     reg_wdata_i,
    output logic [XLEN-1:0]     reg_rdata_o,
    output logic                trap_o,
    output logic [XLEN-1:0]     epc_o
);
    localparam logic [IDX_W-1:0] SEL_STATUS = IDX_W'(IDX_STATUS);

    trap_state_t st_d, st_q;
    logic        exc_valid;
    exc_code_e   exc_code;
    logic        irq_hit;
    logic        unused_wdata;

    assign unused_wdata = ^{reg_wdata_i[XLEN-1:MASK_LSB+NUM_IRQ],
                            reg_wdata_i[MASK_LSB-1:1]};

    trap_exc_encode u_enc (
        .ill_i   (exc_illegal_i),
        .ovf_i   (exc_ovf_i),
        .divz_i  (exc_divz_i),
        .valid_o (exc_valid),
        .code_o  (exc_code)
    );

    trap_irq_gate #(.N(NUM_IRQ)) u_gate (
        .req_i  (irq_i),
        .mask_i (st_q.mask),
        .gie_i  (st_q.gie),
        .hit_o  (irq_hit)
    );

    trap_read_mux #(.W(XLEN), .N(NUM_IRQ), .IW(IDX_W)) u_rd (
        .idx_i   (reg_idx_i),
        .gie_i   (st_q.gie),
        .mask_i  (st_q.mask),
        .code_i  (st_q.code),
        .irq_i   (irq_i),
        .epc_i   (st_q.epc),
        .rdata_o (reg_rdata_o)
    );

    assign trap_o = exc_valid | irq_hit;
    assign epc_o  = st_q.epc;

    always_comb begin
        st_d = st_q;
        if (reg_wr_i && (reg_idx_i == SEL_STATUS)) begin
            st_d.gie  = reg_wdata_i[0];
            st_d.mask = reg_wdata_i[MASK_LSB +: NUM_IRQ];
        end
        if (trap_o) begin
            st_d.gie  = 1'b0;
            st_d.code = exc_valid ? exc_code : CODE_INT;
            st_d.epc  = pc_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{gie: 1'b0, mask: '0, code: CODE_INT, epc: '0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/trap_ctl_checker.sv
module trap_ctl_checker
    import trap_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IRQ-1:0] irq_i,
    input logic               exc_any,
    input logic [XLEN-1:0]    pc_i,
    input logic [IDX_W-1:0]   reg_idx_i,
    input logic [XLEN-1:0]    reg_rdata_o,
    input logic               trap_o,
    input logic [XLEN-1:0]    epc_o,
    input logic               gie_q,
    input logic [NUM_IRQ-1:0] mask_q
);
    p_no_int_when_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!gie_q && !exc_any) |-> !trap_o);

    p_masked_lines_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_any && ((irq_i & mask_q) == '0)) |-> !trap_o);

    p_pending_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx_i == IDX_W'(IDX_CAUSE)) |-> (reg_rdata_o[MASK_LSB +: NUM_IRQ] == irq_i));

    p_exc_traps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_any |-> trap_o);

    p_epc_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> (epc_o == $past(pc_i)));

    p_epc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_o |=> $stable(epc_o));

    p_gie_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> !gie_q);
endmodule

bind trap_ctl_unit trap_ctl_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_i       (irq_i),
    .exc_any     (exc_illegal_i | exc_ovf_i | exc_divz_i),
    .pc_i        (pc_i),
    .reg_idx_i   (reg_idx_i),
    .reg_rdata_o (reg_rdata_o),
    .trap_o      (trap_o),
    .epc_o       (epc_o),
    .gie_q       (st_q.gie),
    .mask_q      (st_q.mask)
);

// File: tb/test_trap_ctl_unit.sv
module test_trap_ctl_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_i = '0;
    logic        exc_illegal_i = 1'b0;
    logic        exc_ovf_i = 1'b0;
    logic        exc_divz_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic [4:0]  reg_idx_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        trap_o;
    logic [31:0] epc_o;

    localparam int K_TRAP = 0;
    localparam int K_EPC  = 1;
    localparam int K_RD   = 2;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
        int          stamp;
    } item_t;

    item_t       sb_q[$];
    item_t       it;
    logic [31:0] act;
    int          cyc = 0;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    trap_ctl_unit i_trap_ctl_unit (
        .clk, .rst_n, .irq_i, .exc_illegal_i, .exc_ovf_i, .exc_divz_i,
        .pc_i, .reg_idx_i, .reg_wr_i, .reg_wdata_i, .reg_rdata_o,
        .trap_o, .epc_o
    );

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops the items stamped for the current cycle
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0 && sb_q[0].stamp == cyc) begin
            it = sb_q.pop_front();
            case (it.kind)
                K_TRAP:  act = {31'b0, trap_o};
                K_EPC:   act = epc_o;
                default: act = reg_rdata_o;
            endcase
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic step(input logic [7:0] irq, input logic [2:0] exc, input logic [31:0] pc,
                        input int idx, input logic wr, input logic [31:0] wd);
        @(negedge clk);
        irq_i         = irq;
        exc_illegal_i = exc[2];
        exc_ovf_i     = exc[1];
        exc_divz_i    = exc[0];
        pc_i          = pc;
        reg_idx_i     = 5'(idx);
        reg_wr_i      = wr;
        reg_wdata_i   = wd;
    endtask

    task automatic expect_v(input int kind, input logic [31:0] exp, input string tag);
        item_t x;
        x.kind = kind; x.exp = exp; x.tag = tag; x.stamp = cyc;
        sb_q.push_back(x);
    endtask

    task automatic idle_rd(input int idx, input logic [31:0] exp, input string tag);
        step(8'h00, 3'b000, 32'h0, idx, 1'b0, 32'h0);
        expect_v(K_RD, exp, tag);
    endtask

    task automatic wr_status(input logic [31:0] wd);
        step(8'h00, 3'b000, 32'h0, 12, 1'b1, wd);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        idle_rd(12, 32'h0, "R10 status reset");
        expect_v(K_EPC, 32'h0, "R10 epc reset");
        expect_v(K_TRAP, 32'h0, "R10 no trap at reset");
        idle_rd(13, 32'h0, "R10 cause reset");
        idle_rd(5, 32'h0, "R10 unmapped index");

        // R1 global enable off, R4 raw pending
        step(8'hFF, 3'b000, 32'h0, 13, 1'b0, 32'h0);
        expect_v(K_TRAP, 32'h0, "R1 disabled no trap");
        expect_v(K_RD, 32'h0000FF00, "R4 raw pending");
        step(8'hFF, 3'b000, 32'h0, 12, 1'b1, 32'h0000FF00);
        step(8'hFF, 3'b000, 32'h0, 12, 1'b0, 32'h0);
        expect_v(K_RD, 32'h0000FF00, "R3 mask stored");
        expect_v(K_TRAP, 32'h0, "R1 masked but disabled");

        // R3 writable bits
        wr_status(32'hFFFF_FFFF);
        idle_rd(12, 32'h0000FF01, "R3 only defined bits");
        wr_status(32'h0000_1001);
        idle_rd(12, 32'h0000_1001, "R3 0x1001 readback");

        // R2 line 3 masked, line 4 enabled
        step(8'h08, 3'b000, 32'h0, 13, 1'b0, 32'h0);
        expect_v(K_TRAP, 32'h0, "R2 masked line");
        expect_v(K_RD, 32'h0000_0800, "R4 pending regardless of mask");
        step(8'h10, 3'b000, 32'h100, 0, 1'b0, 32'h0);
        expect_v(K_TRAP, 32'h1, "R2 enabled line traps");
        step(8'h10, 3'b000, 32'h0, 12, 1'b0, 32'h0);
        expect_v(K_RD, 32'h0000_1000, "R9 enable cleared");
        expect_v(K_TRAP, 32'h0, "R1 no re-entry");
        expect_v(K_EPC, 32'h100, "R8 epc capture");
        idle_rd(13, 32'h0, "R7 interrupt code");
        idle_rd(14, 32'h100, "R8 epc index read");
        step(8'h00, 3'b000, 32'h0, 14, 1'b1, 32'hDEAD);
        idle_rd(14, 32'h100, "R8 epc write ignored");

        // R5 exception codes and priority
        step(8'h00, 3'b100, 32'h200, 0, 1'b0, 32'h0);
        expect_v(K_TRAP, 32'h1, "R5 illegal traps with enable off");
        idle_rd(13, 32'h28, "R5 illegal code");
        expect_v(K_EPC, 32'h200, "R8 epc on exception");
        step(8'h00, 3'b000, 32'h0, 13, 1'b1, 32'hFFFF);
        idle_rd(13, 32'h28, "R4 cause write ignored");
        step(8'h00, 3'b010, 32'h204, 0, 1'b0, 32'h0);
        expect_v(K_TRAP, 32'h1, "R5 overflow traps");
        idle_rd(13, 32'h30, "R5 overflow code");
        step(8'h00, 3'b001, 32'h208, 0, 1'b0, 32'h0);
        idle_rd(13, 32'h34, "R5 divide code");
        expect_v(K_EPC, 32'h208, "R8 epc divide");
        step(8'h00, 3'b011, 32'h20C, 0, 1'b0, 32'h0);
        idle_rd(13, 32'h30, "R5 overflow over divide");
        step(8'h00, 3'b111, 32'h210, 0, 1'b0, 32'h0);
        idle_rd(13, 32'h28, "R5 illegal over all");

        // R6 exception beats interrupt
        wr_status(32'h0000_1001);
        step(8'h10, 3'b001, 32'h300, 0, 1'b0, 32'h0);
        expect_v(K_TRAP, 32'h1, "R6 combined trap");
        idle_rd(13, 32'h34, "R6 exception code wins");
        expect_v(K_EPC, 32'h300, "R8 epc combined");
        idle_rd(12, 32'h0000_1000, "R9 cleared after exception");

        // R9 trap overrides same-cycle write
        wr_status(32'h0000_1001);
        step(8'h10, 3'b000, 32'h400, 12, 1'b1, 32'h0000_FF01);
        expect_v(K_TRAP, 32'h1, "R2 trap during write");
        idle_rd(12, 32'h0000_FF00, "R9 trap overrides enable write");
        expect_v(K_EPC, 32'h400, "R8 epc 0x400");
        idle_rd(0, 32'h0, "R10 index 0 reads zero");
        expect_v(K_EPC, 32'h400, "R8 epc holds");

        // R2 line 0 at bit 8
        wr_status(32'h0000_0101);
        step(8'h01, 3'b000, 32'h500, 0, 1'b0, 32'h0);
        expect_v(K_TRAP, 32'h1, "R2 line 0 traps");
        idle_rd(13, 32'h0, "R7 line 0 code");
        expect_v(K_EPC, 32'h500, "R8 epc line 0");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule